// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block sits after the pixel sampler of a video capture path. Each clock it may receive one pixel: an 8-bit sample for each of three color channels, with a valid strobe and a line-start flag taken from horizontal sync. It sends these samples to two output ports per channel, A and B. It also produces a data-output clock enable and a phase level that downstream logic uses to strobe the ports, and a delayed copy of horizontal sync.

In single-port mode every sample goes to port A. Port B is disabled through its output enable, and an external tri-state wrapper releases the pins. In dual-port mode the pixels of a line alternate between A and B, and the first pixel of each line always goes to A. Dual-port mode has two sub-modes. In parallel mode a pixel pair is launched on both ports in the same cycle, once every two pixels. In interleaved mode only one port changes per pixel. Every result appears exactly one clock after the pixel that causes it, so data, clock enable and sync output stay aligned.

Top module: `pix_pair_demux`

## Requirements
- R1: While reset is asserted and in the first cycle after it, port_a, port_b, port_b_oe, dck_en, dck_ph and hs_out are all 0.
- R2: With dual_mode=0, a valid pixel appears on port_a one cycle later. port_b reads 0 and port_b_oe is 0 in that cycle.
- R3: port_b_oe equals the dual_mode value of the previous cycle. Whenever port_b_oe is 0, port_b reads 0.
- R4: In dual-port mode a valid pixel with line_start=1 is an A pixel. Valid pixels after it alternate B, A, B, and so on until the next line start.
- R5: In parallel mode (dual_mode=1, par_mode=1) an A pixel changes neither port. The following B pixel updates port_a with the held A pixel and port_b with itself, both one cycle after the B pixel.
- R6: In interleaved mode (dual_mode=1, par_mode=0) an A pixel updates only port_a and a B pixel updates only port_b, each one cycle later.
- R7: dck_en pulses one cycle after each valid pixel in single-port mode. In dual-port mode it pulses only one cycle after B pixels, so it never pulses in two consecutive cycles.
- R8: In dual-port mode dck_ph shows the slot of the most recent valid pixel (0 for A, 1 for B), one cycle late. It therefore toggles at half the pixel rate and returns to 0 after a line start. In single-port mode dck_ph is 0.
- R9: hs_out equals hs_in delayed by exactly one cycle.
- R10: A cycle with pix_vld=0 changes neither port and does not advance the A/B alternation.
- R11: Channel c occupies bits [c*8+7 : c*8] of pix_in, port_a and port_b, and the highest bit of each slice is the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode | input | 1 | 1 selects two-port output |
| par_mode | input | 1 | 1 selects parallel pairs in dual mode, 0 selects interleaved |
| pix_vld | input | 1 | A pixel is present on pix_in this cycle |
| line_start | input | 1 | This valid pixel is the first of a line |
| hs_in | input | 1 | Horizontal sync input |
| pix_in | input | 24 | Three channel samples, channel c at bits c*8 upward |
| port_a | output | 24 | Port A samples for all channels |
| port_b | output | 24 | Port B samples for all channels, 0 when disabled |
| port_b_oe | output | 1 | Output enable for port B pins |
| dck_en | output | 1 | Data-output clock strobe |
| dck_ph | output | 1 | Half-rate output clock phase level |
| hs_out | output | 1 | Horizontal sync aligned with the data |

## Verification
Every output is registered once, so each result is due in the cycle right after the pixel, mode change or sync edge that causes it. In parallel mode that pixel is the B partner and not the A pixel. The bench drives inputs on the falling edge and keeps a behavioural model that it advances with the same inputs. On the next falling edge it compares every port against the model, so each comparison lands exactly one rising edge after its stimulus. Stalls, line starts in the middle of a pair, and mode switches are placed so that the checks of R4, R5, R6 and R10 each occur at the output cycle where that rule decides the value.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
   typedef enum logic {
      SLOT_A = 1'b0,
      SLOT_B = 1'b1
   } slot_e;
endpackage

// File: rtl/pdm_slot_track.sv
module pdm_slot_track
   import pdm_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pix_vld,
   input  logic  line_start,
   input  logic  dual_mode,
   output slot_e slot
);
   slot_e next_q;

   always_comb begin
      if (line_start || !dual_mode) slot = SLOT_A;
      else                          slot = next_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       next_q <= SLOT_A;
      else if (pix_vld) next_q <= (slot == SLOT_A) ? SLOT_B : SLOT_A;
   end

   // R4: a line-start pixel is an A pixel, so the pixel after it is a B pixel
   assert_line_start_b_next_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (pix_vld && line_start) |=> (next_q == SLOT_B));

   // R10: without a valid pixel the alternation holds still
   assert_stall_holds_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !pix_vld |=> $stable(next_q));
endmodule

// File: rtl/pdm_lane.sv
module pdm_lane
   import pdm_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_vld,
   input  slot_e             slot,
   input  logic              dual_mode,
   input  logic              par_mode,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] a_q,
   output logic [DATA_W-1:0] b_q
);
   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         hold_q <= '0;
      end else if (pix_vld) begin
         if (!dual_mode) begin
            a_q <= din;
         end else if (par_mode) begin
            if (slot == SLOT_A) begin
               hold_q <= din;
            end else begin
               a_q <= hold_q;
               b_q <= din;
            end
         end else begin
            if (slot == SLOT_A) a_q <= din;
            else                b_q <= din;
         end
      end
   end

   // R10: no valid pixel, no port change
   assert_idle_stable_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !pix_vld |=> ($stable(a_q) && $stable(b_q)));

   // R5: in parallel mode an A pixel leaves both ports untouched
   assert_par_a_holds_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (pix_vld && dual_mode && par_mode && slot == SLOT_A) |=> ($stable(a_q) && $stable(b_q)));

   // R6: in interleaved mode a B pixel leaves port A untouched
   assert_ilv_b_only_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (pix_vld && dual_mode && !par_mode && slot == SLOT_B) |=> ($stable(a_q) && b_q == $past(din)));
endmodule

// File: rtl/pdm_clk_out.sv
module pdm_clk_out
   import pdm_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pix_vld,
   input  slot_e slot,
   input  logic  dual_mode,
   input  logic  hs_in,
   output logic  dck_en,
   output logic  dck_ph,
   output logic  port_b_oe,
   output logic  hs_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dck_en    <= 1'b0;
         dck_ph    <= 1'b0;
         port_b_oe <= 1'b0;
         hs_out    <= 1'b0;
      end else begin
         dck_en    <= pix_vld && (!dual_mode || slot == SLOT_B);
         port_b_oe <= dual_mode;
         hs_out    <= hs_in;
         if (!dual_mode)   dck_ph <= 1'b0;
         else if (pix_vld) dck_ph <= (slot == SLOT_B);
      end
   end

   // R7: in dual-port mode the strobe runs at most at half rate
   assert_half_rate_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (dck_en && port_b_oe) |=> !(dck_en && port_b_oe));

   // R8: every dual-mode strobe coincides with the B phase
   assert_strobe_on_b_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (dck_en && port_b_oe) |-> dck_ph);
endmodule

// File: rtl/pix_pair_demux.sv
module pix_pair_demux
   import pdm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NUM_CH = 3
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     dual_mode,
   input  logic                     par_mode,
   input  logic                     pix_vld,
   input  logic                     line_start,
   input  logic                     hs_in,
   input  logic [DATA_W*NUM_CH-1:0] pix_in,
   output logic [DATA_W*NUM_CH-1:0] port_a,
   output logic [DATA_W*NUM_CH-1:0] port_b,
   output logic                     port_b_oe,
   output logic                     dck_en,
   output logic                     dck_ph,
   output logic                     hs_out
);
   localparam int BUS_W = DATA_W * NUM_CH;

   if (DATA_W < 1) begin : g_bad_width
      $error("pix_pair_demux: DATA_W must be at least 1");
   end
   if (NUM_CH < 1) begin : g_bad_count
      $error("pix_pair_demux: NUM_CH must be at least 1");
   end

   slot_e            slot;
   logic [BUS_W-1:0] a_all;
   logic [BUS_W-1:0] b_all;

   pdm_slot_track u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_vld    (pix_vld),
      .line_start (line_start),
      .dual_mode  (dual_mode),
      .slot       (slot)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      pdm_lane #(.DATA_W(DATA_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .pix_vld   (pix_vld),
         .slot      (slot),
         .dual_mode (dual_mode),
         .par_mode  (par_mode),
         .din       (pix_in[c*DATA_W +: DATA_W]),
         .a_q       (a_all[c*DATA_W +: DATA_W]),
         .b_q       (b_all[c*DATA_W +: DATA_W])
      );
   end

   pdm_clk_out u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_vld   (pix_vld),
      .slot      (slot),
      .dual_mode (dual_mode),
      .hs_in     (hs_in),
      .dck_en    (dck_en),
      .dck_ph    (dck_ph),
      .port_b_oe (port_b_oe),
      .hs_out    (hs_out)
   );

   assign port_a = a_all;
   assign port_b = port_b_oe ? b_all : '0;

   // R2: single-port pixel lands on port A with a strobe one cycle later
   assert_single_to_a_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (pix_vld && !dual_mode) |=> (dck_en && port_a == $past(pix_in) && port_b == '0));

   // R4: a dual-mode line start restarts the output phase at A
   assert_line_phase_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (pix_vld && line_start && dual_mode) |=> (!dck_ph && !dck_en));

   // R9: sync output trails its input by one cycle
   assert_hs_delay_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_in) |=> hs_out);
endmodule

// File: tb/sim_pix_pair_demux.sv
module sim_pix_pair_demux;
   localparam int W  = 8;
   localparam int NC = 3;
   localparam int BW = W * NC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dual_mode = 1'b0, par_mode = 1'b0, pix_vld = 1'b0;
   logic          line_start = 1'b0, hs_in = 1'b0;
   logic [BW-1:0] pix_in = '0;
   logic [BW-1:0] port_a, port_b;
   logic          port_b_oe, dck_en, dck_ph, hs_out;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   pix_pair_demux u0 (
      .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .par_mode(par_mode),
      .pix_vld(pix_vld), .line_start(line_start), .hs_in(hs_in), .pix_in(pix_in),
      .port_a(port_a), .port_b(port_b), .port_b_oe(port_b_oe),
      .dck_en(dck_en), .dck_ph(dck_ph), .hs_out(hs_out)
   );

   // behavioural reference state
   logic [W-1:0] m_a [NC];
   logic [W-1:0] m_b [NC];
   logic [W-1:0] m_pend [$];
   bit m_want_b, m_oe, m_en, m_ph, m_hs;
   string tag_a, tag_b;

   task automatic check(input string req, input string what, input logic [BW-1:0] act,
                        input logic [BW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [BW-1:0] pack(input logic [W-1:0] v [NC]);
      logic [BW-1:0] r = '0;
      for (int c = 0; c < NC; c++) r[c*W +: W] = v[c];
      return r;
   endfunction

   // advance the model with the inputs just driven (they take effect at the next rising edge)
   task automatic model_step();
      bit is_b;
      is_b = pix_vld && dual_mode && !line_start && m_want_b;
      tag_a = "R2"; tag_b = "R3";
      if (dual_mode) begin tag_a = par_mode ? "R5" : "R6"; tag_b = tag_a; end
      if (!pix_vld) begin tag_a = "R10"; tag_b = "R10"; end
      else if (line_start && dual_mode) tag_a = "R4";
      if (pix_vld) begin
         if (!dual_mode) begin
            for (int c = 0; c < NC; c++) m_a[c] = pix_in[c*W +: W];
         end else if (!is_b) begin
            if (par_mode) begin
               m_pend.delete();
               for (int c = 0; c < NC; c++) m_pend.push_back(pix_in[c*W +: W]);
            end else begin
               for (int c = 0; c < NC; c++) m_a[c] = pix_in[c*W +: W];
            end
         end else begin
            if (par_mode) begin
               for (int c = 0; c < NC; c++) begin
                  m_a[c] = (m_pend.size() > 0) ? m_pend.pop_front() : '0;
                  m_b[c] = pix_in[c*W +: W];
               end
            end else begin
               for (int c = 0; c < NC; c++) m_b[c] = pix_in[c*W +: W];
            end
         end
         m_want_b = !is_b;
      end
      m_en = pix_vld && (!dual_mode || is_b);
      if (!dual_mode) m_ph = 0;
      else if (pix_vld) m_ph = is_b;
      m_oe = dual_mode;
      m_hs = hs_in;
   endtask

   task automatic compare_all();
      check(tag_a, "port_a", port_a, pack(m_a));
      check(tag_b, "port_b", port_b, m_oe ? pack(m_b) : '0);
      check("R3", "port_b_oe", {{(BW-1){1'b0}}, port_b_oe}, {{(BW-1){1'b0}}, m_oe});
      check("R7", "dck_en", {{(BW-1){1'b0}}, dck_en}, {{(BW-1){1'b0}}, m_en});
      check("R8", "dck_ph", {{(BW-1){1'b0}}, dck_ph}, {{(BW-1){1'b0}}, m_ph});
      check("R9", "hs_out", {{(BW-1){1'b0}}, hs_out}, {{(BW-1){1'b0}}, m_hs});
   endtask

   task automatic drive_rand(input int vld_pct, input int ls_pct);
      logic [31:0] r;
      r = $urandom;
      pix_in = r[BW-1:0];
      pix_vld = (($urandom % 100) < vld_pct);
      line_start = pix_vld && (($urandom % 100) < ls_pct);
      hs_in = (($urandom % 8) == 0);
   endtask

   task automatic run_mode(input bit d, input bit p, input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         compare_all();
         if (i == 0) begin
            dual_mode = d; par_mode = p;
            drive_rand(100, 0);
            pix_vld = 1'b1; line_start = 1'b1;
         end else begin
            drive_rand(75, 6);
         end
         model_step();
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int c = 0; c < NC; c++) begin m_a[c] = '0; m_b[c] = '0; end
      m_want_b = 0; m_oe = 0; m_en = 0; m_ph = 0; m_hs = 0;
      tag_a = "R1"; tag_b = "R1";
      pix_vld = 1'b1; hs_in = 1'b1; pix_in = '1;
      repeat (4) @(negedge clk);
      // R1: outputs stay clear while reset is held
      check("R1", "reset port_a", port_a, '0);
      check("R1", "reset port_b", port_b, '0);
      check("R1", "reset flags", {{(BW-4){1'b0}}, port_b_oe, dck_en, dck_ph, hs_out}, '0);
      rst_n = 1'b1;
      pix_vld = 1'b0; hs_in = 1'b0;
      tag_a = "R1"; tag_b = "R1";
      model_step();

      // R11: channel slicing with distinct per-channel values
      @(negedge clk);
      compare_all();
      pix_vld = 1'b1; line_start = 1'b1; pix_in = 24'hC35A81;
      model_step();
      @(negedge clk);
      check("R11", "channel order", port_a, 24'hC35A81);
      check("R11", "channel 2 MSB", {23'd0, port_a[23]}, 24'd1);
      compare_all();
      pix_vld = 1'b0; line_start = 1'b0;
      model_step();

      run_mode(1'b0, 1'b0, 300);
      run_mode(1'b1, 1'b1, 600);
      run_mode(1'b1, 1'b0, 600);
      run_mode(1'b0, 1'b1, 200);
      run_mode(1'b1, 1'b1, 400);

      @(negedge clk);
      compare_all();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end
endmodule